// File: doc/BRIEF.md
# Multi-Address I2C Target Engine

This block is the target (slave) side of an I2C port. It samples the SCL and SDA lines through a synchronizer and decodes START and STOP conditions. It shifts in the 8-bit address byte that follows a START and compares its upper seven bits against four address slots. When a slot matches, the engine holds SCL low and raises a pending flag. Control logic then reads a 2-bit phase code, the captured byte and the index of the winning slot. It answers with a one-cycle continue or NACK strobe. Only that strobe lets the engine drive the acknowledge bit and release the clock.

After an acknowledged read address the engine asks for transmit bytes and shifts each one out MSB first. After an acknowledged write address it collects each received byte and asks whether to ACK it. A STOP, a NACK from either side, or a disable sends the engine back to watching for the next START. A repeated START restarts address matching at once.

Slot 0 has a don't-care mask. A slot holding address zero answers the general-call write. Setting a slot's low bit switches that slot off.

Top module: `i2cs_engine`

## Requirements
- R1: After reset the pending flag is 0 and the engine drives neither SCL nor SDA low.
- R2: When an address byte matches an enabled slot, the engine raises pending with phase code 0 (address received) at the falling SCL edge that ends the eighth bit. It presents the whole address byte, including R/W in bit 0, on rx_byte and the winning slot number on slot_idx. It holds SCL low for as long as pending is 1.
- R3: A slot whose configuration byte has bit 0 set never matches. The 7-bit slot address sits in bits 7:1. If several slots match, the lowest-numbered one is reported.
- R4: Each bit set in slot0_mask[7:1] makes the address bit at the same position always compare equal for slot 0 only.
- R5: A slot holding address 0 matches the address byte 0x00 (general-call write). It does not match 0x01.
- R6: Continue during phase 0 or 1 drives an ACK (SDA low) for the acknowledge clock and releases SCL. NACK leaves SDA released, releases SCL, and returns the engine to idle with pending staying 0.
- R7: After an acknowledged write address, each further byte raises pending with phase code 1 and puts that byte on rx_byte.
- R8: After an acknowledged read address, the engine raises pending with phase code 2. Continue sends tx_byte MSB first. A controller ACK raises phase 2 pending again. A controller NACK returns the engine to idle with no pending.
- R9: A repeated START during a data phase, followed by a matching address, raises pending with phase code 0 and the new address byte.
- R10: A STOP clears pending and returns the engine to idle, where it drives neither line.
- R11: While slv_en is 0 the engine raises no pending, does not acknowledge any address, and drives neither line.
- R12: Continue or NACK strobes given while pending is 0 have no effect on the bus or on the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (clock hold) |
| sda_oe | output | 1 | 1 pulls SDA low |
| slv_en | input | 1 | Engine enable |
| slot_cfg | input | N_SLOTS*8 | Slot i in bits [8i+7:8i]: address in 7:1, disable in 0 |
| slot0_mask | input | 8 | Don't-care bits for slot 0, in 7:1 |
| cmd_cont | input | 1 | One-cycle continue strobe |
| cmd_nack | input | 1 | One-cycle NACK strobe |
| tx_byte | input | 8 | Byte to send, sampled with continue in phase 2 |
| pend | output | 1 | Waiting for a command |
| phase | output | 2 | 0 address, 1 receive data, 2 transmit request |
| slot_idx | output | IDX_W | Slot that matched last |
| rx_byte | output | 8 | Captured address or data byte |

## Verification
The hardest case to reach is a repeated START that lands inside an acknowledged write phase. The engine has to drop a partially counted byte and restart address matching without a STOP. The bench creates it by acknowledging one data byte and then raising SDA and SCL instead of shifting the next bit. It then pulls SDA low while SCL is high and sends a second, matching read address. The bench models the wired-AND of both lines, so the controller model must wait out each clock hold. Because of that, the pending handshakes and the bit timing interact exactly as they would on a real bus.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  localparam int BYTE_BITS = 8;

  localparam logic [1:0] PH_ADDR = 2'd0;
  localparam logic [1:0] PH_RXD  = 2'd1;
  localparam logic [1:0] PH_TXD  = 2'd2;

  typedef enum logic [2:0] {
    EV_IDLE,
    EV_ADDR,
    EV_HOLD,
    EV_ACK,
    EV_RX,
    EV_TXHOLD,
    EV_TX,
    EV_TXACK
  } eng_st_t;

  // Returns 1 when an address byte hits one slot configuration.
  // dc_mask bits set to 1 compare as equal; a zero slot address
  // answers only the general-call write byte.
  function automatic logic slot_match(input logic [7:0] abyte,
                                      input logic [7:0] cfg,
                                      input logic [6:0] dc_mask);
    logic [6:0] diff;
    if (cfg[0]) return 1'b0;
    if ((cfg[7:1] == 7'd0) && abyte[0]) return 1'b0;
    diff = (abyte[7:1] ^ cfg[7:1]) & ~dc_mask;
    return (diff == 7'd0);
  endfunction

endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_up,
  output logic scl_dn,
  output logic start_seen,
  output logic stop_seen
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_in};
      sda_sh <= {sda_sh[STAGES-2:0], sda_in};
      scl_d  <= scl_sh[STAGES-1];
      sda_d  <= sda_sh[STAGES-1];
    end
  end

  assign scl_lvl    = scl_sh[STAGES-1];
  assign sda_lvl    = sda_sh[STAGES-1];
  assign scl_up     = scl_lvl & ~scl_d;
  assign scl_dn     = ~scl_lvl & scl_d;
  assign start_seen = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_seen  = scl_lvl & scl_d & ~sda_d & sda_lvl;

endmodule

// File: rtl/i2cs_addr_match.sv
module i2cs_addr_match
  import i2cs_pkg::*;
#(
  parameter int N_SLOTS = 4,
  localparam int IDX_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
  localparam int CFG_W = N_SLOTS * 8
) (
  input  logic [7:0]       abyte,
  input  logic [CFG_W-1:0] cfg,
  input  logic [7:0]       mask0,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  logic [N_SLOTS-1:0] raw;

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    if (g == 0) begin : g_masked
      assign raw[g] = slot_match(abyte, cfg[g*8 +: 8], mask0[7:1]);
    end else begin : g_plain
      assign raw[g] = slot_match(abyte, cfg[g*8 +: 8], 7'd0);
    end
  end

  always_comb begin
    idx = '0;
    for (int i = N_SLOTS - 1; i >= 0; i--) begin
      if (raw[i]) idx = IDX_W'(i);
    end
  end

  assign hit = |raw;

  always_comb begin
    if (hit) begin
      AST_WINNER_MATCHES: assert (raw[idx]) else $error("winner slot does not match"); // R3
    end
    for (int j = 0; j < N_SLOTS; j++) begin
      if (hit && (j < int'(idx))) begin
        AST_LOWEST_WINS: assert (!raw[j]) else $error("lower slot skipped"); // R3
      end
    end
  end

endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter int N_SLOTS     = 4,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
  localparam int CFG_W = N_SLOTS * 8,
  localparam int CNT_W = $clog2(BYTE_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic             slv_en,
  input  logic [CFG_W-1:0] slot_cfg,
  input  logic [7:0]       slot0_mask,
  input  logic             cmd_cont,
  input  logic             cmd_nack,
  input  logic [7:0]       tx_byte,
  output logic             pend,
  output logic [1:0]       phase,
  output logic [IDX_W-1:0] slot_idx,
  output logic [7:0]       rx_byte
);
  logic scl_lvl, sda_lvl, scl_up, scl_dn, start_ev, stop_ev;

  i2cs_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_i), .sda_in(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_up(scl_up), .scl_dn(scl_dn),
    .start_seen(start_ev), .stop_seen(stop_ev)
  );

  eng_st_t          st;
  logic [CNT_W-1:0] bit_cnt;
  logic [7:0]       shf;
  logic [7:0]       rx_q;
  logic             rw_q, nak_q, mack_q, pend_q, hold_q, drive_q;
  logic [1:0]       ph_q;
  logic [IDX_W-1:0] idx_q;

  logic             adr_hit;
  logic [IDX_W-1:0] adr_idx;

  i2cs_addr_match #(.N_SLOTS(N_SLOTS)) i_match (
    .abyte(shf), .cfg(slot_cfg), .mask0(slot0_mask),
    .hit(adr_hit), .idx(adr_idx)
  );

  // Named internal events
  logic byte_end, addr_done, rx_done, tx_last, sw_go, sw_stop;
  assign byte_end  = scl_dn && (bit_cnt == CNT_W'(BYTE_BITS));
  assign addr_done = (st == EV_ADDR) && byte_end;
  assign rx_done   = (st == EV_RX) && byte_end;
  assign tx_last   = (st == EV_TX) && scl_dn && (bit_cnt == CNT_W'(BYTE_BITS - 1));
  assign sw_go     = pend_q && cmd_cont;
  assign sw_stop   = pend_q && cmd_nack && !cmd_cont;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= EV_IDLE;
      bit_cnt <= '0;
      shf     <= '0;
      rx_q    <= '0;
      rw_q    <= 1'b0;
      nak_q   <= 1'b0;
      mack_q  <= 1'b0;
      pend_q  <= 1'b0;
      ph_q    <= PH_ADDR;
      idx_q   <= '0;
      hold_q  <= 1'b0;
      drive_q <= 1'b0;
    end else if (!slv_en || stop_ev) begin
      st      <= EV_IDLE;
      pend_q  <= 1'b0;
      hold_q  <= 1'b0;
      drive_q <= 1'b0;
    end else if (start_ev) begin
      st      <= EV_ADDR;
      bit_cnt <= '0;
      pend_q  <= 1'b0;
      hold_q  <= 1'b0;
      drive_q <= 1'b0;
    end else begin
      case (st)
        EV_IDLE: ;
        EV_ADDR, EV_RX: begin
          if (scl_up && (bit_cnt != CNT_W'(BYTE_BITS))) begin
            shf     <= {shf[6:0], sda_lvl};
            bit_cnt <= bit_cnt + 1'b1;
          end
          if (addr_done) begin
            if (adr_hit) begin
              rx_q   <= shf;
              rw_q   <= shf[0];
              idx_q  <= adr_idx;
              pend_q <= 1'b1;
              ph_q   <= PH_ADDR;
              hold_q <= 1'b1;
              st     <= EV_HOLD;
            end else begin
              st <= EV_IDLE;
            end
          end
          if (rx_done) begin
            rx_q   <= shf;
            pend_q <= 1'b1;
            ph_q   <= PH_RXD;
            hold_q <= 1'b1;
            st     <= EV_HOLD;
          end
        end
        EV_HOLD: begin
          if (sw_go || sw_stop) begin
            drive_q <= sw_go;
            nak_q   <= sw_stop;
            pend_q  <= 1'b0;
            hold_q  <= 1'b0;
            st      <= EV_ACK;
          end
        end
        EV_ACK: begin
          if (scl_dn) begin
            drive_q <= 1'b0;
            bit_cnt <= '0;
            if (nak_q) begin
              st <= EV_IDLE;
            end else if ((ph_q == PH_ADDR) && rw_q) begin
              pend_q <= 1'b1;
              ph_q   <= PH_TXD;
              hold_q <= 1'b1;
              st     <= EV_TXHOLD;
            end else begin
              st <= EV_RX;
            end
          end
        end
        EV_TXHOLD: begin
          if (sw_go) begin
            shf     <= tx_byte;
            drive_q <= ~tx_byte[7];
            bit_cnt <= '0;
            pend_q  <= 1'b0;
            hold_q  <= 1'b0;
            st      <= EV_TX;
          end else if (sw_stop) begin
            pend_q <= 1'b0;
            hold_q <= 1'b0;
            st     <= EV_IDLE;
          end
        end
        EV_TX: begin
          if (tx_last) begin
            drive_q <= 1'b0;
            st      <= EV_TXACK;
          end else if (scl_dn) begin
            shf     <= {shf[6:0], 1'b0};
            drive_q <= ~shf[6];
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        EV_TXACK: begin
          if (scl_up) mack_q <= ~sda_lvl;
          if (scl_dn) begin
            if (mack_q) begin
              pend_q <= 1'b1;
              ph_q   <= PH_TXD;
              hold_q <= 1'b1;
              st     <= EV_TXHOLD;
            end else begin
              st <= EV_IDLE;
            end
          end
        end
        default: st <= EV_IDLE;
      endcase
    end
  end

  assign scl_oe   = hold_q;
  assign sda_oe   = drive_q;
  assign pend     = pend_q;
  assign phase    = ph_q;
  assign slot_idx = idx_q;
  assign rx_byte  = rx_q;

  AST_HOLD_WHILE_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> scl_oe) else $error("pending without clock hold"); // R2

  AST_PHASE_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> (phase != 2'd3)) else $error("reserved phase code"); // R2

  AST_CMD_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && (cmd_cont || cmd_nack)) |=> (!pend && !scl_oe)) else $error("command did not release"); // R6

  AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (!pend && !scl_oe && !sda_oe)) else $error("stop left bus driven"); // R10

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !slv_en |=> (!pend && !scl_oe && !sda_oe)) else $error("disabled engine active"); // R11

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (slv_en && $past(slv_en) && $changed(sda_oe)) |-> !$past(scl_lvl)) else $error("SDA moved with SCL high"); // R6

endmodule

// File: tb/test_i2cs_engine.sv
module test_i2cs_engine;
  localparam int H = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic scl_m, sda_m;
  logic scl_oe, sda_oe;
  logic slv_en;
  logic [31:0] slot_cfg;
  logic [7:0] slot0_mask;
  logic sw_cont, sw_nack, stray_cont, stray_nack;
  logic [7:0] tx_byte;
  logic pend;
  logic [1:0] phase;
  logic [1:0] slot_idx;
  logic [7:0] rx_byte;

  wire scl_line = scl_m & ~scl_oe;
  wire sda_line = sda_m & ~sda_oe;
  wire cmd_cont = sw_cont | stray_cont;
  wire cmd_nack = sw_nack | stray_nack;

  i2cs_engine i_i2cs_engine (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .slv_en(slv_en),
    .slot_cfg(slot_cfg), .slot0_mask(slot0_mask),
    .cmd_cont(cmd_cont), .cmd_nack(cmd_nack), .tx_byte(tx_byte),
    .pend(pend), .phase(phase), .slot_idx(slot_idx), .rx_byte(rx_byte)
  );

  typedef struct {
    string      req;
    logic [1:0] ph;
    logic [7:0] dat;
    logic       chk_dat;
    logic [1:0] idx;
    logic       nak;
    logic [7:0] tx;
  } exp_t;

  exp_t sb_q[$];
  int checks = 0;
  int fails  = 0;
  logic oe_when_off = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input string req, input logic [1:0] ph, input logic [7:0] dat,
                      input logic chkd, input logic [1:0] idx, input logic nak,
                      input logic [7:0] tx);
    exp_t e;
    e.req = req; e.ph = ph; e.dat = dat; e.chk_dat = chkd;
    e.idx = idx; e.nak = nak; e.tx = tx;
    sb_q.push_back(e);
  endtask

  // Scoreboard monitor acting as the control side
  initial begin
    sw_cont = 1'b0;
    sw_nack = 1'b0;
    tx_byte = 8'h00;
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && pend === 1'b1) begin
        if (sb_q.size() == 0) begin
          checks++;
          fails++;
          $display("FAIL R3/R11 unexpected pending actual phase=%0d expected none", phase);
          tick(3);
          sw_nack = 1'b1;
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk({e.req, " phase"}, 32'(phase), 32'(e.ph));
          chk({e.req, " slot"}, 32'(slot_idx), 32'(e.idx));
          if (e.chk_dat) chk({e.req, " byte"}, 32'(rx_byte), 32'(e.dat));
          chk({e.req, " clock held"}, 32'(scl_oe), 32'd1);
          tick(3);
          if (e.nak) sw_nack = 1'b1;
          else begin
            tx_byte = e.tx;
            sw_cont = 1'b1;
          end
        end
        tick(1);
        sw_cont = 1'b0;
        sw_nack = 1'b0;
        tick(1);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n === 1'b1 && slv_en === 1'b0 && (scl_oe || sda_oe || pend)) oe_when_off <= 1'b1;
  end

  // Controller model
  task automatic scl_rise;
    scl_m = 1'b1;
    while (scl_line !== 1'b1) tick(1);
    tick(H);
  endtask

  task automatic m_start;
    sda_m = 1'b1; tick(2);
    scl_rise;
    sda_m = 1'b0; tick(H);
    scl_m = 1'b0; tick(H);
  endtask

  task automatic m_stop;
    sda_m = 1'b0; tick(2);
    scl_rise;
    sda_m = 1'b1; tick(H);
  endtask

  task automatic m_write(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(2);
      scl_rise;
      scl_m = 1'b0; tick(H);
    end
    sda_m = 1'b1; tick(2);
    scl_rise;
    acked = (sda_line == 1'b0);
    scl_m = 1'b0; tick(H);
  endtask

  task automatic m_read(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(2);
      scl_rise;
      b[i] = sda_line;
      scl_m = 1'b0; tick(H);
    end
    sda_m = ~give_ack; tick(2);
    scl_rise;
    scl_m = 1'b0; tick(H);
    sda_m = 1'b1;
  endtask

  task automatic drained(input string req);
    tick(30);
    chk({req, " all expected pendings seen"}, 32'(sb_q.size()), 32'd0);
    chk({req, " idle no pending"}, 32'(pend), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] rd;
    rst_n = 1'b0;
    scl_m = 1'b1; sda_m = 1'b1;
    slv_en = 1'b1;
    // slot0 0x50, slot1 general call, slot2 0x23 disabled, slot3 0x66
    slot_cfg = {8'hCC, 8'h47, 8'h00, 8'hA0};
    slot0_mask = 8'h00;
    stray_cont = 1'b0; stray_nack = 1'b0;
    tick(5);
    chk("R1 pend after reset", 32'(pend), 32'd0);
    chk("R1 scl_oe after reset", 32'(scl_oe), 32'd0);
    chk("R1 sda_oe after reset", 32'(sda_oe), 32'd0);
    rst_n = 1'b1;
    tick(5);

    // R2 R7 R6: write to 0x50, two data bytes, second NACKed
    push("R2 addr write", 2'd0, 8'hA0, 1'b1, 2'd0, 1'b0, 8'h00);
    push("R7 rx byte 1", 2'd1, 8'h3C, 1'b1, 2'd0, 1'b0, 8'h00);
    push("R7 rx byte 2", 2'd1, 8'hF1, 1'b1, 2'd0, 1'b1, 8'h00);
    m_start;
    m_write(8'hA0, ack); chk("R6 address ACK on bus", 32'(ack), 32'd1);
    m_write(8'h3C, ack); chk("R6 data ACK on bus", 32'(ack), 32'd1);
    m_write(8'hF1, ack); chk("R6 data NACK on bus", 32'(ack), 32'd0);
    drained("R6 after NACK");
    m_stop;
    chk("R10 lines released after stop", 32'({scl_oe, sda_oe}), 32'd0);

    // R8: read from 0x66, two bytes
    push("R2 addr read", 2'd0, 8'hCD, 1'b1, 2'd3, 1'b0, 8'h00);
    push("R8 tx request 1", 2'd2, 8'h00, 1'b0, 2'd3, 1'b0, 8'h96);
    push("R8 tx request 2", 2'd2, 8'h00, 1'b0, 2'd3, 1'b0, 8'h5A);
    m_start;
    m_write(8'hCD, ack); chk("R2 read address ACK", 32'(ack), 32'd1);
    m_read(1'b1, rd); chk("R8 first byte MSB first", 32'(rd), 32'h96);
    m_read(1'b0, rd); chk("R8 second byte", 32'(rd), 32'h5A);
    drained("R8 after controller NACK");
    chk("R8 SDA released after NACK", 32'(sda_oe), 32'd0);
    m_stop;

    // R3: disabled slot 0x23 is not acknowledged
    m_start;
    m_write(8'h46, ack); chk("R3 disabled slot no ACK", 32'(ack), 32'd0);
    drained("R3 disabled slot");
    m_stop;

    // R5: general call write matches slot 1, read form does not
    push("R5 general call", 2'd0, 8'h00, 1'b1, 2'd1, 1'b0, 8'h00);
    m_start;
    m_write(8'h00, ack); chk("R5 general call ACK", 32'(ack), 32'd1);
    m_stop;
    m_start;
    m_write(8'h01, ack); chk("R5 general call read no ACK", 32'(ack), 32'd0);
    drained("R5");
    m_stop;

    // R4: mask bits 2:1 make address bits 1:0 don't-care on slot 0
    slot0_mask = 8'h06;
    push("R4 masked match", 2'd0, 8'hA6, 1'b1, 2'd0, 1'b1, 8'h00);
    m_start;
    m_write(8'hA6, ack); chk("R4 masked match NACKed by command", 32'(ack), 32'd0);
    m_stop;
    m_start;
    m_write(8'hAE, ack); chk("R4 unmasked bit still compared", 32'(ack), 32'd0);
    drained("R4");
    m_stop;
    slot0_mask = 8'h00;

    // R3 priority: slot3 duplicates slot0
    slot_cfg = {8'hA0, 8'h47, 8'h00, 8'hA0};
    push("R3 lowest slot wins", 2'd0, 8'hA0, 1'b1, 2'd0, 1'b1, 8'h00);
    m_start; m_write(8'hA0, ack); m_stop;
    slot_cfg = {8'hA0, 8'h47, 8'h00, 8'hA1};
    push("R3 disabled slot0 skipped", 2'd0, 8'hA0, 1'b1, 2'd3, 1'b1, 8'h00);
    m_start; m_write(8'hA0, ack); m_stop;
    drained("R3 priority");
    slot_cfg = {8'hCC, 8'h47, 8'h00, 8'hA0};

    // R9: repeated start inside write data phase
    push("R9 first address", 2'd0, 8'hA0, 1'b1, 2'd0, 1'b0, 8'h00);
    push("R9 data", 2'd1, 8'h11, 1'b1, 2'd0, 1'b0, 8'h00);
    push("R9 restart address", 2'd0, 8'hCD, 1'b1, 2'd3, 1'b1, 8'h00);
    m_start;
    m_write(8'hA0, ack);
    m_write(8'h11, ack);
    m_start;
    m_write(8'hCD, ack); chk("R9 restart address NACKed", 32'(ack), 32'd0);
    drained("R9");
    m_stop;

    // R10: stop in the middle of a receive phase
    push("R10 address", 2'd0, 8'hA0, 1'b1, 2'd0, 1'b0, 8'h00);
    m_start;
    m_write(8'hA0, ack);
    m_stop;
    drained("R10 stop mid phase");
    chk("R10 no drive after stop", 32'({scl_oe, sda_oe}), 32'd0);

    // R12: strobes while not pending have no effect
    stray_cont = 1'b1; tick(1); stray_cont = 1'b0; tick(3);
    chk("R12 idle cont no drive", 32'({scl_oe, sda_oe, pend}), 32'd0);
    push("R12 address", 2'd0, 8'hA0, 1'b1, 2'd0, 1'b0, 8'h00);
    push("R12 data after stray nack", 2'd1, 8'h77, 1'b1, 2'd0, 1'b0, 8'h00);
    m_start;
    m_write(8'hA0, ack);
    stray_nack = 1'b1; tick(1); stray_nack = 1'b0; tick(3);
    chk("R12 stray nack no drive", 32'({scl_oe, sda_oe}), 32'd0);
    m_write(8'h77, ack); chk("R12 transfer continues with ACK", 32'(ack), 32'd1);
    m_stop;
    drained("R12");

    // R11: engine disabled ignores a matching address
    slv_en = 1'b0;
    tick(3);
    m_start;
    m_write(8'hA0, ack); chk("R11 disabled no ACK", 32'(ack), 32'd0);
    m_stop;
    drained("R11");
    chk("R11 never drove a line", 32'(oe_when_off), 32'd0);
    slv_en = 1'b1;

    tick(10);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule